// File: doc/BRIEF.md
# Branch Target Buffer

This block is a small fully associative table that the fetch stage reads with the address of the instruction it is about to fetch. Each valid entry pairs a branch address with the last taken target seen for it and a two-bit saturating direction counter. A lookup that matches an entry returns that entry's target and the counter's direction, in the same cycle, so fetch can redirect before decode. A lookup that matches nothing falls back to a fixed rule that uses the kind and the displacement sign supplied by predecode.

Branch resolution writes back through the update port. A resolved branch that is already in the table steps its counter and, when taken, refreshes its target. A taken branch that is not in the table claims an entry. When every entry is in use, a round-robin pointer picks the one to replace. A not-taken branch that is not in the table leaves the table unchanged.

The update port follows the valid/ready convention, but `up_ready` is held high. No back-pressure ever occurs, so an update is accepted in every cycle in which `up_valid` is high. The lookup port is a plain request: it has no handshake, and its outputs are combinational from its inputs and the stored state.

Top module: `btb_top`

## Requirements
- R1: `lk_hit` is 1 only when `lk_valid` is 1 and a valid entry holds an address equal to `lk_pc` in every bit. A lookup's outputs are valid in the same cycle as its inputs.
- R2: On a hit, `lk_target` equals the target stored in the matching entry.
- R3: On a hit, `lk_taken` is bit 1 of the entry's counter. The counter encoding is 0 strongly not-taken, 1 weakly not-taken, 2 weakly taken and 3 strongly taken.
- R4: On a miss with `lk_valid` high, `lk_kind` decides `lk_taken`. Kind 0 (conditional) predicts taken exactly when `lk_backward` is 1. Kinds 1 (call), 2 (unconditional jump) and 3 (other unconditional) always predict taken.
- R5: An update with `up_taken`=1 whose `up_pc` misses allocates the entry at the replacement pointer. The entry receives `up_pc`, `up_target` and counter 2, and it hits from the next cycle on.
- R6: An update with `up_taken`=0 whose `up_pc` misses allocates nothing and does not advance the replacement pointer.
- R7: An update that hits adds 1 to the entry's counter when taken, saturating at 3. When not taken it subtracts 1, saturating at 0.
- R8: A taken update that hits replaces the stored target with `up_target`. The counter keeps its value and takes only the R7 step.
- R9: The replacement pointer starts at entry 0 and advances by one per allocation, wrapping after the last entry. With 16 entries, the 17th allocation since reset evicts the first one.
- R10: With `lk_valid` low, `lk_hit` and `lk_taken` are 0.
- R11: `up_ready` is always 1. A lookup in the same cycle as an update sees the table as it was before that update.
- R12: After reset every entry is invalid and the replacement pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_pc | input | AW | Fetch address looked up |
| lk_kind | input | 2 | Predecoded kind: 0 conditional, 1 call, 2 jump, 3 other unconditional |
| lk_backward | input | 1 | Predecoded displacement is negative |
| lk_hit | output | 1 | Address found in the table |
| lk_target | output | AW | Stored target (meaningful on a hit) |
| lk_taken | output | 1 | Predicted direction |
| up_valid | input | 1 | Resolution update present |
| up_ready | output | 1 | Update accepted (always 1) |
| up_pc | input | AW | Resolved branch address |
| up_target | input | AW | Resolved target address |
| up_taken | input | 1 | Resolved outcome |

## Verification
The lookup results `lk_hit`, `lk_target` and `lk_taken` are due in the same cycle as the lookup inputs. The effect of an update becomes visible after the next rising edge. The bench drives both ports at the falling edge and compares the lookup outputs against its own table model 1 ns later, before the rising edge. It advances the model only after that edge. This order also exercises the rule that a lookup in the same cycle as an update sees the pre-update contents.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef enum logic [1:0] {
    BK_COND  = 2'd0,
    BK_CALL  = 2'd1,
    BK_JUMP  = 2'd2,
    BK_OTHER = 2'd3
  } br_kind_e;

  localparam logic [1:0] CTR_MIN    = 2'd0;
  localparam logic [1:0] CTR_WEAK_T = 2'd2;
  localparam logic [1:0] CTR_MAX    = 2'd3;

  // saturating step of a direction counter
  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic taken);
    logic [1:0] n;
    if (taken) n = (c == CTR_MAX) ? c : c + 2'd1;
    else       n = (c == CTR_MIN) ? c : c - 2'd1;
    return n;
  endfunction

endpackage

// File: rtl/btb_match.sv
module btb_match #(
  parameter int ENTRIES = 16,
  parameter int AW      = 32,
  parameter int IW      = 4
) (
  input  logic [ENTRIES-1:0]         vld,
  input  logic [ENTRIES-1:0][AW-1:0] tags,
  input  logic [AW-1:0]              key,
  output logic [ENTRIES-1:0]         match,
  output logic                       any,
  output logic [IW-1:0]              idx
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld[g] && (tags[g] == key);
  end

  assign any = |match;

  always_comb begin
    idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) idx = idx | IW'(i);
  end

endmodule

// File: rtl/btb_static_pred.sv
module btb_static_pred
  import btb_pkg::*;
(
  input  logic [1:0] kind,
  input  logic       backward,
  output logic       taken
);

  always_comb begin
    unique case (br_kind_e'(kind))
      BK_COND: taken = backward;
      default: taken = 1'b1;
    endcase
  end

endmodule

// File: rtl/btb_victim_ptr.sv
module btb_victim_ptr #(
  parameter int ENTRIES = 16,
  parameter int IW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [IW-1:0] ptr
);

  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  logic [IW-1:0] nxt;

  if ((1 << IW) == ENTRIES) begin : g_pow2
    assign nxt = ptr + 1'b1;
  end else begin : g_wrap
    assign nxt = (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= nxt;
  end

endmodule

// File: rtl/btb_top.sv
module btb_top
  import btb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int AW      = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lk_valid,
  input  logic [AW-1:0] lk_pc,
  input  logic [1:0]    lk_kind,
  input  logic          lk_backward,
  output logic          lk_hit,
  output logic [AW-1:0] lk_target,
  output logic          lk_taken,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic [AW-1:0] up_pc,
  input  logic [AW-1:0] up_target,
  input  logic          up_taken
);

  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]         vld_q;
  logic [ENTRIES-1:0][AW-1:0] pc_q;
  logic [ENTRIES-1:0][AW-1:0] tgt_q;
  logic [ENTRIES-1:0][1:0]    ctr_q;

  logic [ENTRIES-1:0] lk_match, up_match;
  logic               lk_any, up_hit;
  logic [IW-1:0]      lk_idx, up_idx, vptr;
  logic               static_taken, alloc;

  btb_match #(.ENTRIES(ENTRIES), .AW(AW), .IW(IW)) u_lk_match (
    .vld(vld_q), .tags(pc_q), .key(lk_pc),
    .match(lk_match), .any(lk_any), .idx(lk_idx)
  );

  btb_match #(.ENTRIES(ENTRIES), .AW(AW), .IW(IW)) u_up_match (
    .vld(vld_q), .tags(pc_q), .key(up_pc),
    .match(up_match), .any(up_hit), .idx(up_idx)
  );

  btb_static_pred u_static (
    .kind(lk_kind), .backward(lk_backward), .taken(static_taken)
  );

  assign alloc = up_valid && up_taken && !up_hit;

  btb_victim_ptr #(.ENTRIES(ENTRIES), .IW(IW)) u_victim (
    .clk(clk), .rst_n(rst_n), .adv(alloc), .ptr(vptr)
  );

  // lookup side, combinational
  assign lk_hit    = lk_valid && lk_any;
  assign lk_target = tgt_q[lk_idx];
  assign lk_taken  = lk_valid && (lk_any ? ctr_q[lk_idx][1] : static_taken);

  assign up_ready = 1'b1;

  // resolution side
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      pc_q  <= '0;
      tgt_q <= '0;
      ctr_q <= '0;
    end else if (up_valid) begin
      if (up_hit) begin
        ctr_q[up_idx] <= ctr_step(ctr_q[up_idx], up_taken);
        if (up_taken) tgt_q[up_idx] <= up_target;
      end else if (up_taken) begin
        vld_q[vptr] <= 1'b1;
        pc_q[vptr]  <= up_pc;
        tgt_q[vptr] <= up_target;
        ctr_q[vptr] <= CTR_WEAK_T;
      end
    end
  end

  // R1
  match_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match) && $onehot0(up_match));

  // R4
  static_uncond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_any && lk_kind != 2'd0) |-> lk_taken);

  // R5
  alloc_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_taken && !up_hit) |=>
      (vld_q[$past(vptr)] && ctr_q[$past(vptr)] == CTR_WEAK_T && pc_q[$past(vptr)] == $past(up_pc)));

  // R6
  no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_taken && !up_hit) |=> ($stable(vld_q) && $stable(vptr)));

  // R7
  ctr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_hit && !up_taken && ctr_q[up_idx] == CTR_MIN) |=>
      ctr_q[$past(up_idx)] == CTR_MIN);

  // R7
  ctr_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_hit && up_taken && ctr_q[up_idx] == CTR_MAX) |=>
      ctr_q[$past(up_idx)] == CTR_MAX);

endmodule

// File: tb/btb_top_test.sv
`timescale 1ns/1ps
module btb_top_test;

  localparam int N  = 16;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lk_valid = 1'b0;
  logic [AW-1:0] lk_pc = '0;
  logic [1:0]    lk_kind = '0;
  logic          lk_backward = 1'b0;
  logic          lk_hit;
  logic [AW-1:0] lk_target;
  logic          lk_taken;
  logic          up_valid = 1'b0;
  logic          up_ready;
  logic [AW-1:0] up_pc = '0;
  logic [AW-1:0] up_target = '0;
  logic          up_taken = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  btb_top #(.ENTRIES(N), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_kind(lk_kind), .lk_backward(lk_backward),
    .lk_hit(lk_hit), .lk_target(lk_target), .lk_taken(lk_taken),
    .up_valid(up_valid), .up_ready(up_ready), .up_pc(up_pc),
    .up_target(up_target), .up_taken(up_taken)
  );

  // reference model
  bit          m_vld [N];
  logic [31:0] m_pc  [N];
  logic [31:0] m_tgt [N];
  int          m_ctr [N];
  int          m_ptr;

  function automatic int m_find(input logic [31:0] pc);
    for (int i = 0; i < N; i++) if (m_vld[i] && m_pc[i] == pc) return i;
    return -1;
  endfunction

  function automatic bit m_static(input logic [1:0] kind, input bit back);
    return (kind == 2'd0) ? back : 1'b1;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_ctr[i] = 0; end
    m_ptr = 0;
  endtask

  task automatic m_update(input logic [31:0] pc, input logic [31:0] tgt, input bit tk);
    int e;
    e = m_find(pc);
    if (e >= 0) begin
      if (tk) begin
        if (m_ctr[e] < 3) m_ctr[e]++;
        m_tgt[e] = tgt;
      end else if (m_ctr[e] > 0) m_ctr[e]--;
    end else if (tk) begin
      m_vld[m_ptr] = 1; m_pc[m_ptr] = pc; m_tgt[m_ptr] = tgt; m_ctr[m_ptr] = 2;
      m_ptr = (m_ptr + 1) % N;
    end
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, check lookup before rising edge, then advance the model
  task automatic step(input string req,
                      input bit lv, input logic [31:0] lpc, input logic [1:0] lk, input bit lb,
                      input bit uv, input logic [31:0] upc, input logic [31:0] utg, input bit ut);
    int e;
    bit eh, et;
    @(negedge clk);
    lk_valid = lv; lk_pc = lpc; lk_kind = lk; lk_backward = lb;
    up_valid = uv; up_pc = upc; up_target = utg; up_taken = ut;
    #1;
    e  = m_find(lpc);
    eh = lv && (e >= 0);
    et = lv && ((e >= 0) ? (m_ctr[e] >= 2) : m_static(lk, lb));
    chk(req, "hit", 32'(lk_hit), 32'(eh));
    chk(req, "taken", 32'(lk_taken), 32'(et));
    if (eh) chk(req, "target", lk_target, m_tgt[e]);
    if (uv) chk("R11", "up_ready", 32'(up_ready), 32'd1);
    @(posedge clk);
    if (uv) m_update(upc, utg, ut);
  endtask

  task automatic look(input string req, input logic [31:0] pc, input logic [1:0] k, input bit b);
    step(req, 1, pc, k, b, 0, 0, 0, 0);
  endtask

  task automatic upd(input string req, input logic [31:0] pc, input logic [31:0] tg, input bit t);
    step(req, 0, 0, 0, 0, 1, pc, tg, t);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'h5EED);
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R12 reset: nothing hits
    look("R12", 32'h100, 2'd0, 0);
    look("R12", 32'h0, 2'd2, 0);
    // R4 static fallback
    look("R4", 32'h140, 2'd1, 0);
    look("R4", 32'h144, 2'd0, 1);
    look("R4", 32'h148, 2'd0, 0);
    look("R4", 32'h14C, 2'd3, 0);
    // R10 idle lookup
    step("R10", 0, 32'h140, 2'd1, 1, 0, 0, 0, 0);
    // R6 not-taken miss allocates nothing
    upd("R6", 32'h200, 32'h800, 0);
    look("R6", 32'h200, 2'd0, 0);
    // R11 same-cycle lookup sees old state; R5 allocation
    step("R11", 1, 32'h300, 2'd0, 0, 1, 32'h300, 32'h900, 1);
    look("R5", 32'h300, 2'd0, 0);
    look("R2", 32'h300, 2'd0, 0);
    // R1 neighbouring address misses
    look("R1", 32'h304, 2'd0, 0);
    look("R1", 32'h1300, 2'd0, 0);
    // R7 / R3 counter walk
    upd("R7", 32'h300, 32'h0, 0);
    look("R3", 32'h300, 2'd0, 1);
    upd("R7", 32'h300, 32'h0, 0);
    upd("R7", 32'h300, 32'h0, 0);
    look("R7", 32'h300, 2'd0, 1);
    upd("R7", 32'h300, 32'h0, 1);
    look("R7", 32'h300, 2'd0, 1);
    upd("R7", 32'h300, 32'h900, 1);
    upd("R7", 32'h300, 32'h900, 1);
    upd("R7", 32'h300, 32'h900, 1);
    look("R7", 32'h300, 2'd0, 0);
    // R8 target change keeps counter
    upd("R8", 32'h300, 32'hA00, 1);
    upd("R8", 32'h300, 32'hA00, 0);
    look("R8", 32'h300, 2'd0, 0);
    // R9 fill and wrap: 16 new allocations, the last evicts 0x300
    for (int i = 0; i < N; i++) upd("R9", 32'h4000 + 32'(i) * 4, 32'h7000 + 32'(i), 1);
    look("R9", 32'h300, 2'd0, 0);
    look("R9", 32'h4000, 2'd0, 0);
    look("R9", 32'h403C, 2'd0, 0);

    // constrained random traffic from a small address pool
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] a, b;
      a = 32'h1000 + ($urandom % 24) * 4;
      b = 32'h1000 + ($urandom % 24) * 4;
      step("R1", ($urandom % 4) != 0, a, 2'($urandom), 1'($urandom),
           ($urandom % 2) != 0, b, 32'h8000 + ($urandom % 8) * 16, ($urandom % 3) != 0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule